// File: doc/BRIEF.md
# Last Writer History Table

This block remembers, for each memory address that has been written by a committed transaction, the commit timestamp of the most recent writer. A conflict-checking stage feeds it with (address, timestamp) pairs as transactions finish, and asks it which transaction last wrote a given address. Exact pairs live in a small set-associative table. When that table must make room, the displaced pair is not discarded. Its timestamp is folded into one slot of a hashed recency filter, and the slot always keeps the youngest timestamp it has seen.

A lookup returns the exact timestamp when the address is resident in the table. Otherwise it returns the filter slot's timestamp, or "no known writer" when that slot has never been written. Several addresses may share a filter slot, so the filter can report a writer that is too young. It never reports one that is too old. This makes the answer safe for conflict detection, at the cost of some false conflicts.

Top module: `lwh_table`

## Requirements
- R1: After reset every query reports no known writer (`rsp_found`=0), and `rsp_valid` is 0 until a query is issued.
- R2: A query issued in cycle t is answered in cycle t+1 with `rsp_valid`=1. In a cycle with no answer, `rsp_valid`, `rsp_found` and `rsp_exact` are 0 and `rsp_cts` is 0.
- R3: A query for an address held in the exact table returns its stored timestamp with `rsp_found`=1 and `rsp_exact`=1.
- R4: Inserting an address already held in its set overwrites the stored timestamp in place. No other entry of that set is displaced.
- R5: The set index is address bits [3:0], and each set holds 4 addresses. Inserting a new address into a full set displaces the entry that was inserted or updated least recently. Queries do not change this order.
- R6: A displaced entry is folded into filter slot h. Here h is a 6-bit value whose bit k is the XOR of all address bits i with i mod 6 = k. A later query for that address misses the table and returns the slot's timestamp with `rsp_exact`=0 and `rsp_found`=1.
- R7: A filter slot takes a displaced timestamp only when the slot is empty or holds a smaller (older) timestamp. Otherwise it keeps its value.
- R8: A query that misses the table and maps to a filter slot that has never been written returns `rsp_found`=0.
- R9: When an insert and a query name the same address in the same cycle, the answer is the inserted timestamp, with `rsp_exact`=1.
- R10: For any sequence of inserts with increasing timestamps, a query for a previously written address returns `rsp_found`=1 and a timestamp no smaller than that of its true last writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request this cycle |
| ins_addr | input | ADDR_W | Address written by the finishing transaction |
| ins_cts | input | CTS_W | Commit timestamp of that transaction |
| qry_valid | input | 1 | Lookup request this cycle |
| qry_addr | input | ADDR_W | Address to look up |
| rsp_valid | output | 1 | Answer to last cycle's lookup |
| rsp_found | output | 1 | A writer is known (exact or conservative) |
| rsp_exact | output | 1 | Answer came from the exact table or bypass |
| rsp_cts | output | CTS_W | Timestamp of the last writer (or a younger one) |

## Verification
The hardest case to reach from the ports is a collision in one filter slot between entries from different sets, arriving in both age orders. In one order an older timestamp arrives after a younger one and must be refused. In the other a younger one must replace an older one. Directed stimulus builds aliasing addresses in sets 1, 2 and 3 that all fold to the same slot. It fills each set until its aliasing entry is displaced, so the slot sees a younger, then an older, then a younger timestamp. A long random phase then uses 32 addresses in each of three sets, giving constant displacement, and frequently makes the query address equal to the insert address. Every cycle is compared with a behavioural model, along with the never-too-old guarantee.

// File: rtl/lwh_pkg.sv
package lwh_pkg;

  // Where a lookup answer comes from
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_FILTER = 2'd1,
    SRC_TABLE  = 2'd2,
    SRC_BYPASS = 2'd3
  } lwh_src_e;

endpackage

// File: rtl/lwh_primary.sv
// Exact set-associative address -> timestamp store with LRU replacement.
module lwh_primary #(
  parameter int ADDR_W = 32,
  parameter int CTS_W  = 16,
  parameter int WAYS   = 4,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [CTS_W-1:0]  ins_cts,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_hit,
  output logic [CTS_W-1:0]  qry_cts,
  output logic              evict_valid,
  output logic [ADDR_W-1:0] evict_addr,
  output logic [CTS_W-1:0]  evict_cts
);

  localparam int SET_W = $clog2(SETS);
  localparam int AGE_W = $clog2(WAYS);

  logic [SET_W-1:0] i_set, q_set;
  assign i_set = ins_addr[SET_W-1:0];
  assign q_set = qry_addr[SET_W-1:0];

  logic [ADDR_W-1:0] q_tag [WAYS];
  logic [CTS_W-1:0]  q_val [WAYS];
  logic [ADDR_W-1:0] i_tag [WAYS];
  logic [CTS_W-1:0]  i_val [WAYS];
  logic [WAYS-1:0]   wr_en;

  logic [WAYS-1:0]  vld [SETS];
  logic [AGE_W-1:0] age [SETS][WAYS];

  // One tag/timestamp memory per way, single write port each
  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_way
      logic [ADDR_W-1:0] tag_mem [SETS];
      logic [CTS_W-1:0]  cts_mem [SETS];
      always_ff @(posedge clk) begin
        if (wr_en[gw]) begin
          tag_mem[i_set] <= ins_addr;
          cts_mem[i_set] <= ins_cts;
        end
      end
      assign q_tag[gw] = tag_mem[q_set];
      assign q_val[gw] = cts_mem[q_set];
      assign i_tag[gw] = tag_mem[i_set];
      assign i_val[gw] = cts_mem[i_set];
    end
  endgenerate

  // Lookup side
  logic [WAYS-1:0] q_hit_vec;
  always_comb begin
    qry_cts = '0;
    for (int w = 0; w < WAYS; w++) begin
      q_hit_vec[w] = vld[q_set][w] && (q_tag[w] == qry_addr);
      if (q_hit_vec[w]) qry_cts = q_val[w];
    end
  end
  assign qry_hit = |q_hit_vec;

  // Insert side: match, victim choice, target way
  logic [WAYS-1:0]  i_hit_vec;
  logic             i_hit_any;
  logic [AGE_W-1:0] hit_way, victim_way, tgt_way;
  logic             have_free;

  always_comb begin
    hit_way    = '0;
    victim_way = '0;
    have_free  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      i_hit_vec[w] = vld[i_set][w] && (i_tag[w] == ins_addr);
      if (i_hit_vec[w]) hit_way = AGE_W'(w);
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!have_free && !vld[i_set][w]) begin
        victim_way = AGE_W'(w);
        have_free  = 1'b1;
      end
    end
    if (!have_free) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age[i_set][w] == AGE_W'(WAYS-1)) victim_way = AGE_W'(w);
      end
    end
  end

  assign i_hit_any = |i_hit_vec;
  assign tgt_way   = i_hit_any ? hit_way : victim_way;

  always_comb begin
    for (int w = 0; w < WAYS; w++) wr_en[w] = ins_valid && (tgt_way == AGE_W'(w));
  end

  assign evict_valid = ins_valid && !i_hit_any && !have_free;
  assign evict_addr  = i_tag[victim_way];
  assign evict_cts   = i_val[victim_way];

  // Valid bits and recency ages (0 = most recent)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        for (int w = 0; w < WAYS; w++) age[s][w] <= AGE_W'(w);
      end
    end else if (ins_valid) begin
      vld[i_set][tgt_way] <= 1'b1;
      for (int w = 0; w < WAYS; w++) begin
        if (AGE_W'(w) == tgt_way)
          age[i_set][w] <= '0;
        else if (age[i_set][w] < age[i_set][tgt_way])
          age[i_set][w] <= age[i_set][w] + 1'b1;
      end
    end
  end

  // R3: an address is resident in at most one way
  a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q_hit_vec));

  // R4: an in-place update leaves the set occupancy unchanged
  a_r4_update_keeps_set: assert property (@(posedge clk) disable iff (rst)
    ins_valid && i_hit_any |=> vld[$past(i_set)] == $past(vld[i_set]));

  // R5: displacement only happens from a completely full set
  a_r5_evict_full_set: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> &vld[i_set]);

endmodule

// File: rtl/lwh_filter.sv
// Hashed recency filter: each slot keeps the youngest displaced timestamp.
module lwh_filter #(
  parameter int ADDR_W = 32,
  parameter int CTS_W  = 16,
  parameter int SLOTS  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [CTS_W-1:0]  evict_cts,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              slot_found,
  output logic [CTS_W-1:0]  slot_cts
);

  localparam int IDX_W = $clog2(SLOTS);

  function automatic logic [IDX_W-1:0] fold(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < ADDR_W; i++) h[i % IDX_W] = h[i % IDX_W] ^ a[i];
    return h;
  endfunction

  logic [CTS_W-1:0] slot_mem [SLOTS];
  logic [SLOTS-1:0] slot_vld;
  logic [IDX_W-1:0] e_idx, q_idx;
  logic             wr;

  assign e_idx = fold(evict_addr);
  assign q_idx = fold(qry_addr);
  assign wr    = evict_valid && (!slot_vld[e_idx] || (slot_mem[e_idx] < evict_cts));

  always_ff @(posedge clk) begin
    if (wr) slot_mem[e_idx] <= evict_cts;
  end

  always_ff @(posedge clk) begin
    if (rst) slot_vld <= '0;
    else if (wr) slot_vld[e_idx] <= 1'b1;
  end

  assign slot_found = slot_vld[q_idx];
  assign slot_cts   = slot_mem[q_idx];

  // R7: after a displacement the slot holds at least that timestamp
  a_r7_slot_covers_evict: assert property (@(posedge clk) disable iff (rst)
    evict_valid |=> slot_vld[$past(e_idx)] && (slot_mem[$past(e_idx)] >= $past(evict_cts)));

  // R7: an occupied slot never moves to an older timestamp
  a_r7_slot_never_older: assert property (@(posedge clk) disable iff (rst)
    evict_valid && slot_vld[e_idx] |=> slot_mem[$past(e_idx)] >= $past(slot_mem[e_idx]));

endmodule

// File: rtl/lwh_table.sv
// Last writer history: exact table backed by a conservative hashed filter.
module lwh_table
  import lwh_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CTS_W  = 16,
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int SLOTS  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [CTS_W-1:0]  ins_cts,
  input  logic              qry_valid,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              rsp_valid,
  output logic              rsp_found,
  output logic              rsp_exact,
  output logic [CTS_W-1:0]  rsp_cts
);

  logic              p_hit;
  logic [CTS_W-1:0]  p_cts;
  logic              ev_valid;
  logic [ADDR_W-1:0] ev_addr;
  logic [CTS_W-1:0]  ev_cts;
  logic              f_found;
  logic [CTS_W-1:0]  f_cts;

  lwh_primary #(
    .ADDR_W(ADDR_W), .CTS_W(CTS_W), .WAYS(WAYS), .SETS(SETS)
  ) u_primary (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_cts(ins_cts),
    .qry_addr(qry_addr), .qry_hit(p_hit), .qry_cts(p_cts),
    .evict_valid(ev_valid), .evict_addr(ev_addr), .evict_cts(ev_cts)
  );

  lwh_filter #(
    .ADDR_W(ADDR_W), .CTS_W(CTS_W), .SLOTS(SLOTS)
  ) u_filter (
    .clk(clk), .rst(rst),
    .evict_valid(ev_valid), .evict_addr(ev_addr), .evict_cts(ev_cts),
    .qry_addr(qry_addr), .slot_found(f_found), .slot_cts(f_cts)
  );

  lwh_src_e src;
  always_comb begin
    if (ins_valid && (ins_addr == qry_addr)) src = SRC_BYPASS;
    else if (p_hit)                          src = SRC_TABLE;
    else if (f_found)                        src = SRC_FILTER;
    else                                     src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_found <= 1'b0;
      rsp_exact <= 1'b0;
      rsp_cts   <= '0;
    end else begin
      rsp_valid <= qry_valid;
      rsp_found <= qry_valid && (src != SRC_NONE);
      rsp_exact <= qry_valid && ((src == SRC_TABLE) || (src == SRC_BYPASS));
      unique case (src)
        SRC_BYPASS: rsp_cts <= qry_valid ? ins_cts : '0;
        SRC_TABLE:  rsp_cts <= qry_valid ? p_cts   : '0;
        SRC_FILTER: rsp_cts <= qry_valid ? f_cts   : '0;
        default:    rsp_cts <= '0;
      endcase
    end
  end

  // R2: answer follows the query by exactly one cycle
  a_r2_answer_next: assert property (@(posedge clk) disable iff (rst)
    qry_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !qry_valid |=> !rsp_valid && !rsp_found && !rsp_exact);

  // R3: an exact answer is always a found answer
  a_r3_exact_found: assert property (@(posedge clk) disable iff (rst)
    rsp_exact |-> rsp_found);

  // R9: same-address insert and query see the new timestamp
  a_r9_bypass: assert property (@(posedge clk) disable iff (rst)
    ins_valid && qry_valid && (ins_addr == qry_addr)
    |=> rsp_found && rsp_exact && (rsp_cts == $past(ins_cts)));

endmodule

// File: tb/lwh_table_test.sv
module lwh_table_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic [31:0] ins_addr = '0;
  logic [15:0] ins_cts = '0;
  logic        qry_valid = 1'b0;
  logic [31:0] qry_addr = '0;
  logic        rsp_valid, rsp_found, rsp_exact;
  logic [15:0] rsp_cts;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  lwh_table uut (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_cts(ins_cts),
    .qry_valid(qry_valid), .qry_addr(qry_addr),
    .rsp_valid(rsp_valid), .rsp_found(rsp_found),
    .rsp_exact(rsp_exact), .rsp_cts(rsp_cts)
  );

  // Behavioural model
  int m_cts [int];          // resident address -> timestamp
  int m_lru [16][$];        // per set, front = least recent
  int m_slot [64];
  bit m_slot_v [64];
  int m_truth [int];        // true last writer

  function automatic int hash6(input int a);
    int h = 0;
    for (int i = 0; i < 32; i++) if (a[i]) h = h ^ (1 << (i % 6));
    return h;
  endfunction

  task automatic check(input string tag, input bit ok, input string got, input string exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", tag, got, exp);
    end
  endtask

  task automatic step(input bit iv, input int ia, input int ic,
                      input bit qv, input int qa, input string tag);
    bit e_found, e_exact;
    int e_cts, s, idx, victim, h;
    bit has_truth;
    int truth_v;
    ins_valid = iv; ins_addr = ia; ins_cts = 16'(ic);
    qry_valid = qv; qry_addr = qa;
    // expected answer from pre-insert state
    e_found = 0; e_exact = 0; e_cts = 0;
    if (iv && ia == qa) begin e_found = 1; e_exact = 1; e_cts = ic; end
    else if (m_cts.exists(qa)) begin e_found = 1; e_exact = 1; e_cts = m_cts[qa]; end
    else if (m_slot_v[hash6(qa)]) begin e_found = 1; e_cts = m_slot[hash6(qa)]; end
    has_truth = (iv && ia == qa) || m_truth.exists(qa);
    truth_v   = (iv && ia == qa) ? ic : (m_truth.exists(qa) ? m_truth[qa] : 0);
    if (!qv) begin e_found = 0; e_exact = 0; e_cts = 0; end
    // apply insert
    if (iv) begin
      s = ia & 15;
      if (m_cts.exists(ia)) begin
        idx = -1;
        foreach (m_lru[s][k]) if (m_lru[s][k] == ia) idx = k;
        m_lru[s].delete(idx);
      end else if (m_lru[s].size() == 4) begin
        victim = m_lru[s].pop_front();
        h = hash6(victim);
        if (!m_slot_v[h] || m_slot[h] < m_cts[victim]) begin
          m_slot[h] = m_cts[victim]; m_slot_v[h] = 1;
        end
        m_cts.delete(victim);
      end
      m_lru[s].push_back(ia);
      m_cts[ia] = ic;
      m_truth[ia] = ic;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " answer"},
          rsp_valid == qv && rsp_found == e_found && rsp_exact == e_exact && int'(rsp_cts) == e_cts,
          $sformatf("v%0d f%0d x%0d c%0d", rsp_valid, rsp_found, rsp_exact, rsp_cts),
          $sformatf("v%0d f%0d x%0d c%0d", qv, e_found, e_exact, e_cts));
    if (qv && has_truth)
      check("R10 never older", rsp_found && int'(rsp_cts) >= truth_v,
            $sformatf("f%0d c%0d", rsp_found, rsp_cts), $sformatf(">= %0d", truth_v));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset idle", rsp_valid == 0 && rsp_found == 0,
          $sformatf("v%0d f%0d", rsp_valid, rsp_found), "v0 f0");
    step(0, 0, 0, 1, 32'h01, "R1 empty query");
    step(0, 0, 0, 1, 32'hC2, "R1 empty query 2");
    step(0, 0, 0, 0, 0,      "R2 idle cycle");
    step(1, 32'h05, 3, 0, 0, "R3 insert");
    step(0, 0, 0, 1, 32'h05, "R3 exact hit");
    step(1, 32'h15, 4, 1, 32'h15, "R9 bypass");
    step(1, 32'h05, 5, 1, 32'h15, "R4 update keeps neighbour");
    step(0, 0, 0, 1, 32'h05, "R4 updated value");
    step(0, 0, 0, 1, 32'h25, "R8 unknown address");
    // filter aliasing: 0x01, 0xC2, 0x83 all fold to slot 1
    step(1, 32'hC2, 10, 0, 0, "R5 fill set2");
    step(1, 32'h01, 11, 0, 0, "R5 fill set1");
    step(1, 32'h11, 12, 0, 0, "R5 fill set1");
    step(1, 32'h21, 13, 0, 0, "R5 fill set1");
    step(1, 32'h31, 14, 0, 0, "R5 fill set1");
    step(1, 32'h41, 15, 1, 32'h01, "R5 query before displacement");
    step(0, 0, 0, 1, 32'h01, "R6 displaced to filter");
    step(0, 0, 0, 1, 32'h11, "R5 survivor stays exact");
    step(1, 32'h12, 16, 0, 0, "R5 fill set2");
    step(1, 32'h22, 17, 0, 0, "R5 fill set2");
    step(1, 32'h32, 18, 0, 0, "R5 fill set2");
    step(1, 32'h42, 19, 0, 0, "R7 older displaced");
    step(0, 0, 0, 1, 32'hC2, "R7 older refused");
    step(1, 32'h83, 20, 0, 0, "R5 fill set3");
    step(1, 32'h13, 21, 0, 0, "R5 fill set3");
    step(1, 32'h23, 22, 0, 0, "R5 fill set3");
    step(1, 32'h33, 23, 0, 0, "R5 fill set3");
    step(1, 32'h43, 24, 0, 0, "R7 younger displaced");
    step(0, 0, 0, 1, 32'h01, "R7 younger accepted");
    step(1, 32'h11, 25, 0, 0, "R5 update refreshes");
    step(1, 32'h51, 26, 0, 0, "R5 displaces oldest");
    step(0, 0, 0, 1, 32'h11, "R5 refreshed kept");
    step(0, 0, 0, 1, 32'h21, "R6 lru victim in filter");
    step(0, 0, 0, 1, 32'h31, "R5 query leaves order");
    step(1, 32'h61, 27, 0, 0, "R5 displaces next");
    step(0, 0, 0, 1, 32'h31, "R5 queried entry displaced");
    // random phase
    c = 100;
    for (int n = 0; n < 4000; n++) begin
      bit iv, qv;
      int ia, qa;
      iv = ($urandom_range(0, 9) < 6);
      qv = ($urandom_range(0, 9) < 7);
      ia = ($urandom_range(0, 31) << 4) | $urandom_range(0, 2);
      qa = ($urandom_range(0, 3) == 0) ? ia
           : (($urandom_range(0, 31) << 4) | $urandom_range(0, 2));
      if (iv) c++;
      step(iv, ia, c, qv, qa, "R10 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule